// File: doc/BRIEF.md
# Interleaved Flash Command Word Builder

This block prepares command cycles for a bank of identical flash devices that sit side by side on a shared data bus. Given a one-byte command and a logical command offset, it produces the physical byte address to write and the full-width data word. The address is the offset scaled by the device width and the interleave count. The data word carries the command once in every device's lane. For the same strobe it also folds a status word read back from the bank into one status value for a single device. It does this by ORing the lanes of all devices together.

The geometry arrives on three small inputs: the bus width in bytes, the interleave count and the device width in bytes. One control bit selects whether device lanes of two or four bytes use reversed byte order. All results are registered on the clock edge that follows a valid strobe, and a matching valid flag comes out with them. A geometry that has no legal lane layout raises an error flag and forces every result to zero.

Top module: `ilv_cmd_builder`

## Requirements
- R1: For a legal geometry, `addr_o` equals `ofs_i` multiplied by `dev_bytes_i` and then by `ilv_i`, zero-extended to the address width.
- R2: When `dev_bytes_i * ilv_i` is greater than `bus_bytes_i` and `ofs_i[7:0]` equals 8'hAA, `addr_o` is additionally ORed with `(dev_bytes_i / 2) * ilv_i`. If either condition does not hold, no bit is added.
- R3: A geometry is legal only under all of the following conditions. `bus_bytes_i` is 1, 2, 4 or 8 and no more than MAX_BUS_BYTES. `ilv_i` is 1, 2, 4 or 8 and no more than `bus_bytes_i`. The lane width `bus_bytes_i / ilv_i` is 1, 2 or 4. `dev_bytes_i` is 1, 2 or 4. For any other geometry, `err_o` is 1 and `addr_o`, `data_o` and `status_o` are 0.
- R4: With `swap_i` = 0, `data_o` holds `ilv_i` lanes of `bus_bytes_i / ilv_i` bytes each. Lane n occupies bytes n*lane .. n*lane+lane-1, and each lane carries the command byte in its least significant byte with zeros above it. All bits at and above bit `bus_bytes_i*8` are 0.
- R5: With `swap_i` = 1 and a lane width of 2 or 4 bytes, each lane carries the command byte in its most significant byte. With a lane width of 1, `swap_i` has no effect on `data_o`.
- R6: With `swap_i` = 0, `status_o` is the bitwise OR of the `ilv_i` lanes of `sts_i`, zero-extended to 32 bits. Each lane is taken as a little-endian value of lane width.
- R7: With `swap_i` = 1 and a lane width of 2 or 4, the merged lane value of R6 is byte-reversed within the lane width before it is placed on `status_o`.
- R8: `out_vld_o` is 1 in exactly the cycle after a cycle with `cmd_vld_i` = 1. The other outputs update only on such edges and hold their value otherwise.
- R9: Synchronous reset `rst` clears `out_vld_o`, `err_o`, `addr_o`, `data_o` and `status_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld_i | input | 1 | Strobe: capture a new command and status |
| cmd_byte_i | input | 8 | Logical command byte |
| ofs_i | input | OFS_W | Logical command offset |
| bus_bytes_i | input | 4 | Bus width in bytes |
| ilv_i | input | 4 | Number of interleaved devices |
| dev_bytes_i | input | 3 | Device width in bytes |
| swap_i | input | 1 | Reverse byte order inside 2- and 4-byte lanes |
| sts_i | input | MAX_BUS_BYTES*8 | Status word read from the bank |
| out_vld_o | output | 1 | Results valid for the previous strobe |
| err_o | output | 1 | Illegal geometry |
| addr_o | output | OFS_W+2+clog2(MAX_BUS_BYTES) | Physical byte address |
| data_o | output | MAX_BUS_BYTES*8 | Replicated command word |
| status_o | output | 32 | Merged per-device status |

## Verification
Command replication and status merging share one strobe and one register stage, so one capture edge updates both from unrelated inputs. The bench drives every vector with a non-zero status word next to the command. It then compares `data_o`, `addr_o` and `status_o` in the same sample. A slip of one path against the other, or a lane mix-up that affects only one of them, therefore shows as a mismatch. The swap bit is shared as well. Vectors with the swap set test the reversal in both directions in the same cycle: the command goes into device order and the status comes back out of it.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;

  // Encodes 1/2/4/8 as {legal, log2}; anything else gives legal = 0.
  function automatic logic [2:0] pow2_code(input logic [3:0] v);
    case (v)
      4'd1:    return 3'b100;
      4'd2:    return 3'b101;
      4'd4:    return 3'b110;
      4'd8:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  // Reverses the byte order of the low lane_b bytes (1, 2 or 4).
  function automatic logic [31:0] lane_swap(input logic [31:0] v,
                                            input logic [2:0]  lane_b);
    case (lane_b)
      3'd2:    return {16'h0000, v[7:0], v[15:8]};
      3'd4:    return {v[7:0], v[15:8], v[23:16], v[31:24]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/cmdw_geom.sv
module cmdw_geom #(
  parameter int MAX_BUS_BYTES = 8
) (
  input  logic [3:0] bus_bytes_i,
  input  logic [3:0] ilv_i,
  input  logic [2:0] dev_bytes_i,
  output logic       geo_err_o,
  output logic [2:0] lane_b_o,
  output logic [1:0] ilv_log_o,
  output logic [2:0] addr_sh_o,
  output logic       compat_o
);
  import cmdw_pkg::*;

  localparam logic [4:0] MAX_B = 5'(MAX_BUS_BYTES);

  logic [2:0] bus_c, ilv_c, dev_c;
  logic [1:0] lane_log;
  logic       bus_ok, ilv_ok, lane_ok, dev_ok;

  always_comb begin
    bus_c    = pow2_code(bus_bytes_i);
    ilv_c    = pow2_code(ilv_i);
    dev_c    = pow2_code({1'b0, dev_bytes_i});
    bus_ok   = bus_c[2] && ({1'b0, bus_bytes_i} <= MAX_B);
    ilv_ok   = ilv_c[2] && (ilv_c[1:0] <= bus_c[1:0]);
    lane_log = bus_c[1:0] - ilv_c[1:0];
    lane_ok  = (lane_log != 2'd3);
    dev_ok   = dev_c[2];
    geo_err_o = !(bus_ok && ilv_ok && lane_ok && dev_ok);
    case (lane_log)
      2'd0:    lane_b_o = 3'd1;
      2'd1:    lane_b_o = 3'd2;
      default: lane_b_o = 3'd4;
    endcase
    ilv_log_o = ilv_c[1:0];
    addr_sh_o = {1'b0, dev_c[1:0]} + {1'b0, ilv_c[1:0]};
    // device span wider than the bus: narrow-bus compatibility addressing
    compat_o  = addr_sh_o > {1'b0, bus_c[1:0]};
  end

endmodule

// File: rtl/cmdw_addr.sv
module cmdw_addr #(
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 21
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [2:0]        addr_sh_i,
  input  logic              compat_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] half_bit;
  logic              aa_hit;

  always_comb begin
    scaled   = ADDR_W'(ofs_i) << addr_sh_i;
    aa_hit   = (ofs_i[7:0] == 8'hAA);
    half_bit = (addr_sh_i == 3'd0) ? '0 : (ADDR_W'(1) << (addr_sh_i - 3'd1));
    addr_o   = (compat_i && aa_hit) ? (scaled | half_bit) : scaled;
  end

endmodule

// File: rtl/cmdw_lane_rep.sv
module cmdw_lane_rep #(
  parameter int DATA_W = 64,
  localparam int NSTG  = $clog2(DATA_W / 8)
) (
  input  logic [7:0]        cmd_i,
  input  logic              swap_i,
  input  logic [2:0]        lane_b_i,
  input  logic [1:0]        ilv_log_i,
  output logic [DATA_W-1:0] data_o
);
  import cmdw_pkg::*;

  logic [31:0]       seed;
  logic [DATA_W-1:0] stg [NSTG+1];

  always_comb begin
    seed   = swap_i ? lane_swap({24'h0, cmd_i}, lane_b_i) : {24'h0, cmd_i};
    stg[0] = DATA_W'(seed);
  end

  // Doubling: stage k copies the pattern up by lane*2^k bytes.
  for (genvar k = 0; k < NSTG; k++) begin : g_dbl
    logic [8:0] shamt;
    always_comb begin
      shamt      = 9'(lane_b_i) << (3 + k);
      stg[k + 1] = (ilv_log_i > 2'(k)) ? (stg[k] | (stg[k] << shamt)) : stg[k];
    end
  end

  assign data_o = stg[NSTG];

endmodule

// File: rtl/cmdw_sts_merge.sv
module cmdw_sts_merge #(
  parameter int DATA_W = 64,
  localparam int NSTG  = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] sts_i,
  input  logic              swap_i,
  input  logic [2:0]        lane_b_i,
  input  logic [1:0]        ilv_log_i,
  output logic [31:0]       status_o
);
  import cmdw_pkg::*;

  logic [DATA_W-1:0] stg [NSTG+1];
  logic [DATA_W-1:0] lane_mask;
  logic [31:0]       merged;

  assign stg[0] = sts_i;

  // Folding: stage k ORs in the lanes lying lane*2^k bytes higher.
  for (genvar k = 0; k < NSTG; k++) begin : g_fold
    logic [8:0] shamt;
    always_comb begin
      shamt      = 9'(lane_b_i) << (3 + k);
      stg[k + 1] = (ilv_log_i > 2'(k)) ? (stg[k] | (stg[k] >> shamt)) : stg[k];
    end
  end

  always_comb begin
    lane_mask = (DATA_W'(1) << (9'(lane_b_i) << 3)) - DATA_W'(1);
    merged    = 32'(stg[NSTG] & lane_mask);
    status_o  = swap_i ? lane_swap(merged, lane_b_i) : merged;
  end

endmodule

// File: rtl/ilv_cmd_builder.sv
module ilv_cmd_builder #(
  parameter int MAX_BUS_BYTES = 8,
  parameter int OFS_W         = 16,
  localparam int DATA_W       = MAX_BUS_BYTES * 8,
  localparam int ADDR_W       = OFS_W + 2 + $clog2(MAX_BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld_i,
  input  logic [7:0]        cmd_byte_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [3:0]        bus_bytes_i,
  input  logic [3:0]        ilv_i,
  input  logic [2:0]        dev_bytes_i,
  input  logic              swap_i,
  input  logic [DATA_W-1:0] sts_i,
  output logic              out_vld_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [31:0]       status_o
);

  logic              geo_err;
  logic [2:0]        lane_b;
  logic [1:0]        ilv_log;
  logic [2:0]        addr_sh;
  logic              compat;
  logic [ADDR_W-1:0] addr_c;
  logic [DATA_W-1:0] data_c;
  logic [31:0]       status_c;

  cmdw_geom #(.MAX_BUS_BYTES(MAX_BUS_BYTES)) geom_i (
    .bus_bytes_i(bus_bytes_i), .ilv_i(ilv_i), .dev_bytes_i(dev_bytes_i),
    .geo_err_o(geo_err), .lane_b_o(lane_b), .ilv_log_o(ilv_log),
    .addr_sh_o(addr_sh), .compat_o(compat)
  );

  cmdw_addr #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) addr_i (
    .ofs_i(ofs_i), .addr_sh_i(addr_sh), .compat_i(compat), .addr_o(addr_c)
  );

  cmdw_lane_rep #(.DATA_W(DATA_W)) rep_i (
    .cmd_i(cmd_byte_i), .swap_i(swap_i), .lane_b_i(lane_b),
    .ilv_log_i(ilv_log), .data_o(data_c)
  );

  cmdw_sts_merge #(.DATA_W(DATA_W)) merge_i (
    .sts_i(sts_i), .swap_i(swap_i), .lane_b_i(lane_b),
    .ilv_log_i(ilv_log), .status_o(status_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_o <= 1'b0;
      err_o     <= 1'b0;
      addr_o    <= '0;
      data_o    <= '0;
      status_o  <= '0;
    end else begin
      out_vld_o <= cmd_vld_i;
      if (cmd_vld_i) begin
        err_o    <= geo_err;
        addr_o   <= geo_err ? '0 : addr_c;
        data_o   <= geo_err ? '0 : data_c;
        status_o <= geo_err ? '0 : status_c;
      end
    end
  end

  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_i |=> out_vld_o);
  // R8
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld_i |=> (!out_vld_o && $stable(data_o) && $stable(addr_o) && $stable(status_o)));
  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_i && geo_err) |=> (err_o && data_o == '0 && addr_o == '0 && status_o == '0));
  // R4
  low_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_i && !geo_err && !swap_i) |=> (data_o[7:0] == $past(cmd_byte_i)));
  // R1
  unit_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_i && !geo_err && dev_bytes_i == 3'd1 && ilv_i == 4'd1)
      |=> (addr_o == ADDR_W'($past(ofs_i))));
  // R6
  sts_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_i && !geo_err && sts_i == '0) |=> (status_o == 32'h0));

endmodule

// File: tb/ilv_cmd_builder_tb_top.sv
module ilv_cmd_builder_tb_top;

  localparam int MAXB   = 8;
  localparam int OFSW   = 16;
  localparam int DW     = MAXB * 8;
  localparam int AW     = OFSW + 2 + $clog2(MAXB);
  localparam int NVEC   = 14;

  typedef struct packed {
    logic [3:0]    bus;
    logic [3:0]    ilv;
    logic [2:0]    dev;
    logic          swp;
    logic [7:0]    cmd;
    logic [15:0]   ofs;
    logic [63:0]   sts;
    logic [AW-1:0] ea;
    logic [63:0]   ed;
    logic [31:0]   es;
    logic          ee;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{4'd1, 4'd1, 3'd1, 1'b0, 8'h98, 16'h0055, 64'h80,                  21'h00055, 64'h98,                  32'h80,       1'b0},
    '{4'd2, 4'd1, 3'd2, 1'b0, 8'hF0, 16'h00AA, 64'h1234,                21'h00154, 64'h00F0,                32'h1234,     1'b0},
    '{4'd1, 4'd1, 3'd2, 1'b0, 8'hAA, 16'h0AAA, 64'h05,                  21'h01555, 64'hAA,                  32'h05,       1'b0},
    '{4'd4, 4'd2, 3'd2, 1'b0, 8'h98, 16'h0055, 64'h0080_0001,           21'h00154, 64'h0098_0098,           32'h0081,     1'b0},
    '{4'd4, 4'd2, 3'd2, 1'b1, 8'h98, 16'h0055, 64'h0100_8000,           21'h00154, 64'h9800_9800,           32'h0081,     1'b0},
    '{4'd8, 4'd8, 3'd1, 1'b0, 8'h90, 16'h02AA, 64'h0100_0000_0000_0002, 21'h01550, 64'h9090_9090_9090_9090, 32'h03,       1'b0},
    '{4'd8, 4'd2, 3'd4, 1'b1, 8'h70, 16'h0010, 64'h0000_0001_8000_0000, 21'h00080, 64'h7000_0000_7000_0000, 32'h0100_0080, 1'b0},
    '{4'd2, 4'd1, 3'd4, 1'b0, 8'h98, 16'h05AA, 64'h00FF,                21'h016AA, 64'h0098,                32'h00FF,     1'b0},
    '{4'd8, 4'd1, 3'd1, 1'b0, 8'h98, 16'h0055, 64'hFFFF,                21'h0,     64'h0,                   32'h0,        1'b1},
    '{4'd3, 4'd1, 3'd1, 1'b0, 8'h98, 16'h0055, 64'hFF,                  21'h0,     64'h0,                   32'h0,        1'b1},
    '{4'd2, 4'd4, 3'd1, 1'b0, 8'h98, 16'h0055, 64'hFF,                  21'h0,     64'h0,                   32'h0,        1'b1},
    '{4'd4, 4'd2, 3'd3, 1'b0, 8'h98, 16'h0055, 64'hFF,                  21'h0,     64'h0,                   32'h0,        1'b1},
    '{4'd4, 4'd4, 3'd1, 1'b0, 8'h98, 16'h00AA, 64'h0102_0408,           21'h002A8, 64'h9898_9898,           32'h0F,       1'b0},
    '{4'd4, 4'd2, 3'd4, 1'b1, 8'h55, 16'h01AA, 64'h0,                   21'h00D54, 64'h5500_5500,           32'h0,        1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_vld_i = 1'b0;
  logic [7:0]    cmd_byte_i = '0;
  logic [15:0]   ofs_i = '0;
  logic [3:0]    bus_bytes_i = 4'd1;
  logic [3:0]    ilv_i = 4'd1;
  logic [2:0]    dev_bytes_i = 3'd1;
  logic          swap_i = 1'b0;
  logic [DW-1:0] sts_i = '0;
  logic          out_vld_o, err_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;
  logic [31:0]   status_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ilv_cmd_builder #(.MAX_BUS_BYTES(MAXB), .OFS_W(OFSW)) dut_i (
    .clk(clk), .rst(rst), .cmd_vld_i(cmd_vld_i), .cmd_byte_i(cmd_byte_i),
    .ofs_i(ofs_i), .bus_bytes_i(bus_bytes_i), .ilv_i(ilv_i),
    .dev_bytes_i(dev_bytes_i), .swap_i(swap_i), .sts_i(sts_i),
    .out_vld_o(out_vld_o), .err_o(err_o), .addr_o(addr_o),
    .data_o(data_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    bus_bytes_i = v.bus; ilv_i = v.ilv; dev_bytes_i = v.dev; swap_i = v.swp;
    cmd_byte_i = v.cmd; ofs_i = v.ofs; sts_i = v.sts;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    chk($sformatf("R8 vec%0d out_vld", idx), 64'(out_vld_o), 64'd1);
    chk($sformatf("R3 vec%0d err", idx), 64'(err_o), 64'(v.ee));
    chk($sformatf("R1/R2 vec%0d addr", idx), 64'(addr_o), 64'(v.ea));
    chk($sformatf("R4/R5 vec%0d data", idx), data_o, v.ed);
    chk($sformatf("R6/R7 vec%0d status", idx), 64'(status_o), 64'(v.es));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_vld", 64'(out_vld_o), 64'd0);
    chk("R9 err", 64'(err_o), 64'd0);
    chk("R9 data", data_o, 64'd0);
    chk("R9 addr", 64'(addr_o), 64'd0);
    chk("R9 status", 64'(status_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i]);
      cmd_vld_i = 1'b1;
      @(negedge clk);
      cmd_vld_i = 1'b0;
      check_vec(VEC[i], i);
    end

    // R8: no strobe, changed inputs -> outputs hold, valid low
    load(VEC[0]);
    @(negedge clk);
    chk("R8 hold out_vld", 64'(out_vld_o), 64'd0);
    chk("R8 hold data", data_o, VEC[NVEC-1].ed);
    chk("R8 hold addr", 64'(addr_o), 64'(VEC[NVEC-1].ea));

    // R8: back-to-back strobes, each result in its own cycle
    load(VEC[5]);
    cmd_vld_i = 1'b1;
    @(negedge clk);
    check_vec(VEC[5], 5);
    load(VEC[6]);
    @(negedge clk);
    cmd_vld_i = 1'b0;
    check_vec(VEC[6], 6);
    @(negedge clk);
    chk("R8 after burst out_vld", 64'(out_vld_o), 64'd0);

    // R5: lane width 1 ignores swap
    load(VEC[5]);
    swap_i = 1'b1;
    cmd_vld_i = 1'b1;
    @(negedge clk);
    cmd_vld_i = 1'b0;
    chk("R5 swap on 1-byte lanes data", data_o, 64'h9090_9090_9090_9090);
    chk("R7 swap on 1-byte lanes status", 64'(status_o), 64'h03);

    // R2: low byte not AA -> no compat bit even in compat geometry
    load(VEC[2]);
    ofs_i = 16'h0AAB;
    cmd_vld_i = 1'b1;
    @(negedge clk);
    cmd_vld_i = 1'b0;
    chk("R2 no AA addr", 64'(addr_o), 64'h1556);

    // R9: reset clears after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 mid reset data", data_o, 64'd0);
    chk("R9 mid reset addr", 64'(addr_o), 64'd0);
    chk("R9 mid reset status", 64'(status_o), 64'd0);

    @(negedge clk);
    finish_run();
  end

endmodule